// File: doc/BRIEF.md
# Process-ID Relocation and Domain Access Checker

This block sits in front of an address translation buffer. It does two things. First, it relocates every virtual address that falls in the lowest 32 MB window by the current process identifier. Tasks that are all linked at the same low addresses therefore land in separate 32 MB slots of a modified address space. Addresses above that window pass through unchanged, so shared system code and data keep one address for every task.

The same block also judges a completed translation. It reads the two-bit rights of the page's domain from a 16-entry domain rights register. It then applies the page's two-bit permission code, taking account of the access direction, the privilege level and two global override bits. One override opens locked pages for privileged reads only. The other opens them for reads in either mode.

A single register write port loads the 7-bit process identifier and the 32-bit domain rights register. A task switch is therefore two writes, and neither the page tables nor the translation buffer needs to be flushed.

Top module: `pid_domain_guard`

## Requirements
- R1: After reset the process identifier is 0 and every domain holds rights 00. A low address then leaves unchanged, and any valid check raises the domain fault.
- R2: When address bits [31:25] are all zero, `mva` equals `va + pid * 0x0200_0000`. This output is combinational.
- R3: When any of address bits [31:25] is set, `mva` equals `va`.
- R4: A write with `cfg_we`=1 and `cfg_sel`=0 loads `cfg_wdata[31:25]` as the process identifier and ignores the lower bits. The old identifier still applies before the clock edge that takes the write. The new one applies from the next cycle.
- R5: A write with `cfg_we`=1 and `cfg_sel`=1 loads the domain rights register. Domain d takes its rights from bits [2d+1:2d], and `chk_domain` selects the domain.
- R6: Rights 00 (no access) and rights 10 (reserved) raise `dom_fault` and never `perm_fault`.
- R7: Rights 11 (manager) raise neither fault, whatever the page permission code is.
- R8: Rights 01 (client) apply the page code `chk_ap`. Code 11 allows all accesses. Code 10 faults only user writes. Code 01 faults every user access. Code 00 faults unless an override below applies.
- R9: With `sys_ovr`=1, a client page with code 00 allows privileged reads.
- R10: With `rom_ovr`=1, a client page with code 00 allows reads in both modes. When both override bits are set, reads in both modes are allowed.
- R11: A write to a client page with code 00 raises `perm_fault`, whatever the override bits are.
- R12: With `chk_valid`=0, both fault outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 selects the process identifier, 1 selects the domain rights |
| cfg_wdata | input | 32 | Register write data |
| va | input | 32 | Virtual address from the core |
| mva | output | 32 | Relocated (modified) address |
| chk_valid | input | 1 | A completed translation is presented for checking |
| chk_domain | input | 4 | Domain number of the translated page |
| chk_ap | input | 2 | Page permission code |
| chk_write | input | 1 | 1 for a write access, 0 for a read |
| chk_priv | input | 1 | 1 for a privileged access, 0 for a user access |
| sys_ovr | input | 1 | Global override: opens locked pages for privileged reads |
| rom_ovr | input | 1 | Global override: opens locked pages for reads in both modes |
| dom_fault | output | 1 | Domain fault |
| perm_fault | output | 1 | Permission fault |

## Verification
Relocation is swept over all 128 process identifiers, using the window's bottom, top and middle addresses. This separates a true add-by-slot from a wrong shift or a wrong window edge. Addresses just above the window and at the top of memory show that a wrong window test would move them.

A manager setting is walked across each of the 16 domain fields while every domain is probed. This exposes a mis-indexed field select. The full cross of rights, permission code, direction, privilege and both override bits tells the two overrides apart from each other. It also separates reads from writes on locked pages.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    typedef enum logic [1:0] {
        DOM_NONE    = 2'b00,
        DOM_CLIENT  = 2'b01,
        DOM_RSVD    = 2'b10,
        DOM_MANAGER = 2'b11
    } dom_rights_e;

    typedef enum logic [1:0] {
        AP_LOCKED    = 2'b00,
        AP_PRIV_ONLY = 2'b01,
        AP_USER_READ = 2'b10,
        AP_OPEN      = 2'b11
    } page_ap_e;

    localparam logic CFG_SEL_PID = 1'b0;
    localparam logic CFG_SEL_DOM = 1'b1;

endpackage

// File: rtl/pdc_cfg_regs.sv
module pdc_cfg_regs #(
    parameter int DATA_W  = 32,
    parameter int PID_W   = 7,
    parameter int DOM_CNT = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic                   cfg_sel,
    input  logic [DATA_W-1:0]      cfg_wdata,
    output logic [PID_W-1:0]       pid_q,
    output logic [2*DOM_CNT-1:0]   dacr_q
);
    import pdc_pkg::*;

    localparam int DACR_W = 2 * DOM_CNT;

    // Process identifier: taken from the top bits of the write word.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pid_q <= '0;
        end else if (cfg_we && (cfg_sel == CFG_SEL_PID)) begin
            pid_q <= cfg_wdata[DATA_W-1 -: PID_W];
        end
    end

    // Domain rights: two bits per domain, domain 0 in the lowest pair.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dacr_q <= '0;
        end else if (cfg_we && (cfg_sel == CFG_SEL_DOM)) begin
            dacr_q <= cfg_wdata[DACR_W-1:0];
        end
    end

endmodule

// File: rtl/pdc_reloc.sv
module pdc_reloc #(
    parameter int ADDR_W = 32,
    parameter int PID_W  = 7
) (
    input  logic [ADDR_W-1:0] va,
    input  logic [PID_W-1:0]  pid,
    output logic [ADDR_W-1:0] mva
);
    localparam int WIN_LSB = ADDR_W - PID_W;

    logic in_window;

    // The window is the lowest slot, so adding pid * slot size is the
    // same as placing pid into the cleared upper field.
    assign in_window = (va[ADDR_W-1:WIN_LSB] == '0);

    always_comb begin
        if (in_window) begin
            mva = {pid, va[WIN_LSB-1:0]};
        end else begin
            mva = va;
        end
    end

endmodule

// File: rtl/pdc_rights_sel.sv
module pdc_rights_sel #(
    parameter int DOM_CNT = 16,
    localparam int IDX_W  = $clog2(DOM_CNT)
) (
    input  logic [2*DOM_CNT-1:0]  dacr,
    input  logic [IDX_W-1:0]      dom_idx,
    output pdc_pkg::dom_rights_e  rights
);
    import pdc_pkg::*;

    logic [1:0] field [DOM_CNT];

    for (genvar g = 0; g < DOM_CNT; g++) begin : g_field
        assign field[g] = dacr[2*g +: 2];
    end

    assign rights = dom_rights_e'(field[dom_idx]);

endmodule

// File: rtl/pdc_access_eval.sv
module pdc_access_eval (
    input  logic                  valid,
    input  pdc_pkg::dom_rights_e  rights,
    input  pdc_pkg::page_ap_e     ap,
    input  logic                  is_write,
    input  logic                  is_priv,
    input  logic                  sys_ovr,
    input  logic                  rom_ovr,
    output logic                  dom_fault,
    output logic                  perm_fault
);
    import pdc_pkg::*;

    logic rd_ok;
    logic wr_ok;

    // Page-level permission decode, including the global overrides.
    always_comb begin
        unique case (ap)
            AP_LOCKED: begin
                rd_ok = rom_ovr | (sys_ovr & is_priv);
                wr_ok = 1'b0;
            end
            AP_PRIV_ONLY: begin
                rd_ok = is_priv;
                wr_ok = is_priv;
            end
            AP_USER_READ: begin
                rd_ok = 1'b1;
                wr_ok = is_priv;
            end
            AP_OPEN: begin
                rd_ok = 1'b1;
                wr_ok = 1'b1;
            end
            default: begin
                rd_ok = 1'b0;
                wr_ok = 1'b0;
            end
        endcase
    end

    // Domain rights decide whether the page decode is consulted at all.
    always_comb begin
        dom_fault  = 1'b0;
        perm_fault = 1'b0;
        if (valid) begin
            unique case (rights)
                DOM_NONE, DOM_RSVD: dom_fault = 1'b1;
                DOM_CLIENT:         perm_fault = is_write ? !wr_ok : !rd_ok;
                DOM_MANAGER:        perm_fault = 1'b0;
                default:            dom_fault = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/pid_domain_guard.sv
module pid_domain_guard #(
    parameter int ADDR_W  = 32,
    parameter int PID_W   = 7,
    parameter int DOM_CNT = 16,
    localparam int IDX_W  = $clog2(DOM_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic [ADDR_W-1:0] va,
    output logic [ADDR_W-1:0] mva,
    input  logic              chk_valid,
    input  logic [IDX_W-1:0]  chk_domain,
    input  logic [1:0]        chk_ap,
    input  logic              chk_write,
    input  logic              chk_priv,
    input  logic              sys_ovr,
    input  logic              rom_ovr,
    output logic              dom_fault,
    output logic              perm_fault
);
    import pdc_pkg::*;

    logic [PID_W-1:0]     pid_q;
    logic [2*DOM_CNT-1:0] dacr_q;
    dom_rights_e          sel_rights;

    pdc_cfg_regs #(
        .DATA_W  (ADDR_W),
        .PID_W   (PID_W),
        .DOM_CNT (DOM_CNT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .pid_q     (pid_q),
        .dacr_q    (dacr_q)
    );

    pdc_reloc #(
        .ADDR_W (ADDR_W),
        .PID_W  (PID_W)
    ) u_reloc (
        .va  (va),
        .pid (pid_q),
        .mva (mva)
    );

    pdc_rights_sel #(
        .DOM_CNT (DOM_CNT)
    ) u_rsel (
        .dacr    (dacr_q),
        .dom_idx (chk_domain),
        .rights  (sel_rights)
    );

    pdc_access_eval u_eval (
        .valid      (chk_valid),
        .rights     (sel_rights),
        .ap         (page_ap_e'(chk_ap)),
        .is_write   (chk_write),
        .is_priv    (chk_priv),
        .sys_ovr    (sys_ovr),
        .rom_ovr    (rom_ovr),
        .dom_fault  (dom_fault),
        .perm_fault (perm_fault)
    );

endmodule

// File: rtl/pdc_guard_chk.sv
module pdc_guard_chk #(
    parameter int ADDR_W  = 32,
    parameter int PID_W   = 7,
    parameter int DOM_CNT = 16,
    localparam int IDX_W  = $clog2(DOM_CNT)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              cfg_sel,
    input logic [ADDR_W-1:0] cfg_wdata,
    input logic [ADDR_W-1:0] va,
    input logic [ADDR_W-1:0] mva,
    input logic              chk_valid,
    input logic [IDX_W-1:0]  chk_domain,
    input logic [1:0]        chk_ap,
    input logic              chk_write,
    input logic              dom_fault,
    input logic              perm_fault
);
    localparam int WIN_LSB = ADDR_W - PID_W;

    // Shadow copies rebuilt from the write port only.
    logic [PID_W-1:0]     sh_pid;
    logic [2*DOM_CNT-1:0] sh_dacr;
    logic [1:0]           sh_rights;
    logic                 low_va;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_pid  <= '0;
            sh_dacr <= '0;
        end else if (cfg_we) begin
            if (cfg_sel) sh_dacr <= cfg_wdata[2*DOM_CNT-1:0];
            else         sh_pid  <= cfg_wdata[ADDR_W-1:WIN_LSB];
        end
    end

    assign sh_rights = sh_dacr[{chk_domain, 1'b0} +: 2];
    assign low_va    = (va[ADDR_W-1:WIN_LSB] == '0);

    a_r2_low_reloc: assert property (@(posedge clk) disable iff (!rst_n)
        low_va |-> (mva == va + (ADDR_W'(sh_pid) << WIN_LSB)));

    a_r3_high_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !low_va |-> (mva == va));

    a_r6_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !sh_rights[0]) |-> (dom_fault && !perm_fault));

    a_r7_manager: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && sh_rights == 2'b11) |-> (!dom_fault && !perm_fault));

    a_r11_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && sh_rights == 2'b01 && chk_write && chk_ap == 2'b00)
            |-> perm_fault);

    a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |-> (!dom_fault && !perm_fault));

endmodule

bind pid_domain_guard pdc_guard_chk #(
    .ADDR_W  (ADDR_W),
    .PID_W   (PID_W),
    .DOM_CNT (DOM_CNT)
) u_guard_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .va         (va),
    .mva        (mva),
    .chk_valid  (chk_valid),
    .chk_domain (chk_domain),
    .chk_ap     (chk_ap),
    .chk_write  (chk_write),
    .dom_fault  (dom_fault),
    .perm_fault (perm_fault)
);

// File: tb/pid_domain_guard_tb_top.sv
module pid_domain_guard_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] va = '0;
    logic [31:0] mva;
    logic        chk_valid = 1'b0;
    logic [3:0]  chk_domain = '0;
    logic [1:0]  chk_ap = '0;
    logic        chk_write = 1'b0;
    logic        chk_priv = 1'b0;
    logic        sys_ovr = 1'b0;
    logic        rom_ovr = 1'b0;
    logic        dom_fault;
    logic        perm_fault;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pid_domain_guard dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .va         (va),
        .mva        (mva),
        .chk_valid  (chk_valid),
        .chk_domain (chk_domain),
        .chk_ap     (chk_ap),
        .chk_write  (chk_write),
        .chk_priv   (chk_priv),
        .sys_ovr    (sys_ovr),
        .rom_ovr    (rom_ovr),
        .dom_fault  (dom_fault),
        .perm_fault (perm_fault)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_sel   = sel;
        cfg_wdata = data;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // Expected {dom_fault, perm_fault} from the requirement tables.
    function automatic logic [1:0] exp_faults(input logic v, input logic [1:0] rt,
        input logic [1:0] ap, input logic wr, input logic pv, input logic s, input logic r);
        logic rd, wok;
        if (!v) return 2'b00;
        if (rt == 2'b00 || rt == 2'b10) return 2'b10;
        if (rt == 2'b11) return 2'b00;
        case (ap)
            2'b11:   begin rd = 1'b1; wok = 1'b1; end
            2'b10:   begin rd = 1'b1; wok = pv;   end
            2'b01:   begin rd = pv;   wok = pv;   end
            default: begin rd = r | (s & pv); wok = 1'b0; end
        endcase
        return {1'b0, wr ? !wok : !rd};
    endfunction

    function automatic string tag_of(input logic [1:0] rt, input logic [1:0] ap,
        input logic wr, input logic pv, input logic s, input logic r);
        if (rt == 2'b00 || rt == 2'b10) return "R6";
        if (rt == 2'b11) return "R7";
        if (ap != 2'b00) return "R8";
        if (wr) return "R11";
        if (r) return "R10";
        if (s && pv) return "R9";
        return "R8";
    endfunction

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        va = 32'h0000_1234;
        chk_valid = 1'b1; chk_domain = 4'd0; chk_ap = 2'b11;
        #2;
        check("R1 mva", mva, 32'h0000_1234);
        check("R1 dom_fault", {31'b0, dom_fault}, 32'd1);
        check("R1 perm_fault", {31'b0, perm_fault}, 32'd0);
        chk_valid = 1'b0;

        // R2/R4: sweep all process identifiers
        for (int p = 0; p < 128; p++) begin
            logic [31:0] prev;
            prev = 32'(((p + 127) % 128)) << 25;
            if (p == 0) prev = 32'h0000_0000;
            @(negedge clk);
            cfg_we = 1'b1; cfg_sel = 1'b0;
            cfg_wdata = (32'(p) << 25) | 32'h01AB_5A5A;
            va = 32'h0000_0040;
            #2;
            check("R4 old id before edge", mva, prev + 32'h40);
            @(negedge clk);
            cfg_we = 1'b0;
            foreach (prev[i]) begin end
            for (int k = 0; k < 3; k++) begin
                logic [31:0] a;
                a = (k == 0) ? 32'h0000_0000 : (k == 1) ? 32'h01FF_FFFF : 32'h00AB_CDEF;
                va = a;
                #2;
                check("R2 relocation", mva, a + (32'(p) << 25));
            end
        end

        // R3: addresses above the window
        write_reg(1'b0, 32'hAA00_0000);
        for (int k = 0; k < 4; k++) begin
            logic [31:0] a;
            a = (k == 0) ? 32'h0200_0000 : (k == 1) ? 32'hFFFF_FFFF :
                (k == 2) ? 32'h7E00_0001 : 32'h8000_0000;
            @(negedge clk);
            va = a;
            #2;
            check("R3 passthrough", mva, a);
        end
        va = 32'h0000_0010;
        #2;
        check("R4 low bits ignored", mva, 32'hAA00_0010);

        // R5: field positions of the domain rights register
        for (int d = 0; d < 16; d++) begin
            write_reg(1'b1, 32'h3 << (2 * d));
            for (int q = 0; q < 16; q++) begin
                @(negedge clk);
                chk_valid = 1'b1; chk_domain = 4'(q); chk_ap = 2'b00;
                chk_write = 1'b1; chk_priv = 1'b0; sys_ovr = 1'b0; rom_ovr = 1'b0;
                #2;
                check("R5 field select", {30'b0, dom_fault, perm_fault},
                      (q == d) ? 32'd0 : 32'd2);
            end
        end

        // R6..R11: full cross on domain 5
        for (int rt = 0; rt < 4; rt++) begin
            write_reg(1'b1, 32'(rt) << 10);
            for (int c = 0; c < 64; c++) begin
                logic [1:0] ap;
                logic wr, pv, s, r;
                ap = c[1:0]; wr = c[2]; pv = c[3]; s = c[4]; r = c[5];
                @(negedge clk);
                chk_valid = 1'b1; chk_domain = 4'd5; chk_ap = ap;
                chk_write = wr; chk_priv = pv; sys_ovr = s; rom_ovr = r;
                #2;
                check(tag_of(2'(rt), ap, wr, pv, s, r), {30'b0, dom_fault, perm_fault},
                      {30'b0, exp_faults(1'b1, 2'(rt), ap, wr, pv, s, r)});
            end
        end

        // R12: no check presented
        for (int rt = 0; rt < 4; rt++) begin
            write_reg(1'b1, 32'(rt) << 10);
            @(negedge clk);
            chk_valid = 1'b0; chk_domain = 4'd5; chk_ap = 2'b00; chk_write = 1'b1;
            #2;
            check("R12 idle", {30'b0, dom_fault, perm_fault}, 32'd0);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule